// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for every cycle of a four-beat burst on a pipelined synchronous memory. A cycle with the step input low and the chip selected starts a burst. It captures the external address and the access direction. Each following cycle with the step input high moves to the next beat. Only the two least significant address bits change during a burst. They follow either a wrapping count or an XOR pattern, and the order input picks which one when the burst starts.

A separate active-high stall input freezes the whole block. A start cycle issued while the chip is not selected ends any burst in progress and does not begin a new one. The outputs are registered state. They change on the clock edge after the cycle that caused the change.

Top module: `burst_addr_seq`

## Requirements
- R1: A non-stalled cycle with `step`=0 and `sel`=1 loads `addr_in`, `wr_in` and `interleave`. On the next cycle `addr_out` equals the loaded address, `wr_out` equals the loaded direction (1 = write), and `active` is 1.
- R2: On a non-stalled cycle with `step`=1, `addr_in` and `wr_in` are ignored. `wr_out` keeps the value it had at load.
- R3: If the burst was loaded with `interleave`=1, then at beat k (k = 0..3) `addr_out[1:0]` equals the start bits XOR k.
- R4: If the burst was loaded with `interleave`=0, then at beat k `addr_out[1:0]` equals (start bits + k) mod 4.
- R5: After beat 3, a further step returns to beat 0 and the cycle repeats. `addr_out[AW-1:2]` stays fixed for the whole burst.
- R6: While `stall`=1, all other inputs are ignored and `addr_out`, `active` and `wr_out` keep their values.
- R7: A non-stalled cycle with `step`=0 and `sel`=0 clears `active` on the next cycle. It loads nothing: `addr_out` and `wr_out` keep their values.
- R8: A step while `active`=0 changes none of the outputs.
- R9: A change of `interleave` during a burst has no effect until the next load.
- R10: After reset, `addr_out` is 0, `active` is 0 and `wr_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | High freezes all state; all other inputs are ignored |
| sel | input | 1 | Chip selected (all enables true) |
| step | input | 1 | 0 = load a new address, 1 = advance to the next beat |
| addr_in | input | AW | External start address |
| wr_in | input | 1 | Direction at load, 1 = write |
| interleave | input | 1 | Order at load, 1 = XOR pattern, 0 = wrapping count |
| addr_out | output | AW | Address of the current beat |
| active | output | 1 | A burst is in progress |
| wr_out | output | 1 | Direction latched at load |

## Verification
The in-module assertions check, on every cycle, the effects that depend only on the previous cycle: the stall freeze, capture on load, termination on deselect, the fixed direction and upper bits while advancing, and that a step without a burst does nothing. Two things need a reference model in the bench: the exact two-bit sequence in each order across many beats including the wrap, and the fact that an order change in mid-burst is ignored. The scenarios cover both.

// File: rtl/burst_addr_seq.sv
module burst_addr_seq #(
  parameter int AW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall,
  input  logic          sel,
  input  logic          step,
  input  logic [AW-1:0] addr_in,
  input  logic          wr_in,
  input  logic          interleave,
  output logic [AW-1:0] addr_out,
  output logic          active,
  output logic          wr_out
);
  localparam int HI = AW - 1;

  logic [HI:0] base;
  logic [1:0]  beat;
  logic        xor_ord;
  logic [1:0]  low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base    <= '0;
      beat    <= '0;
      xor_ord <= 1'b0;
      active  <= 1'b0;
      wr_out  <= 1'b0;
    end else if (!stall) begin
      if (!step) begin
        if (sel) begin
          base    <= addr_in;
          beat    <= '0;
          xor_ord <= interleave;
          wr_out  <= wr_in;
          active  <= 1'b1;
        end else begin
          active  <= 1'b0;
        end
      end else if (active) begin
        beat <= beat + 2'd1;
      end
    end
  end

  assign low      = xor_ord ? (base[1:0] ^ beat) : (base[1:0] + beat);
  assign addr_out = {base[HI:2], low};

  a_r6_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(addr_out) && $stable(active) && $stable(wr_out));

  a_r1_load_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !step && sel) |=>
      active && addr_out == $past(addr_in) && wr_out == $past(wr_in));

  a_r7_deselect_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !step && !sel) |=> !active && $stable(wr_out) && $stable(addr_out));

  a_r2_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && step) |=> $stable(wr_out));

  a_r5_upper_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && step) |=> $stable(addr_out[HI:2]));

  a_r8_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && step && !active) |=> !active && $stable(addr_out));
endmodule

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int AW = 17;
  localparam int PERIOD = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          stall = 1'b0, sel = 1'b0, step = 1'b0, wr_in = 1'b0, interleave = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [AW-1:0] addr_out;
  logic          active, wr_out;

  burst_addr_seq #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .sel(sel), .step(step),
    .addr_in(addr_in), .wr_in(wr_in), .interleave(interleave),
    .addr_out(addr_out), .active(active), .wr_out(wr_out));

  always #(PERIOD/2) clk = ~clk;

  typedef struct {
    logic [AW-1:0] addr;
    logic          act;
    logic          wr;
    string         tag;
  } exp_t;

  exp_t q[$];
  int applied = 0, bad = 0;
  bit finished = 0;

  logic [AW-1:0] m_base = '0;
  logic [1:0]    m_beat = '0;
  logic          m_act = 0, m_wr = 0, m_ord = 0;

  function automatic logic [AW-1:0] m_addr();
    logic [1:0] lo;
    lo = m_ord ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    return {m_base[AW-1:2], lo};
  endfunction

  task automatic cyc(input logic s_stall, input logic s_sel, input logic s_step,
                     input logic [AW-1:0] s_addr, input logic s_wr, input logic s_il,
                     input string tag);
    exp_t e;
    @(negedge clk);
    stall = s_stall; sel = s_sel; step = s_step;
    addr_in = s_addr; wr_in = s_wr; interleave = s_il;
    if (!s_stall) begin
      if (!s_step) begin
        if (s_sel) begin
          m_base = s_addr; m_beat = 0; m_ord = s_il; m_wr = s_wr; m_act = 1;
        end else m_act = 0;
      end else if (m_act) m_beat = m_beat + 2'd1;
    end
    e.addr = m_addr(); e.act = m_act; e.wr = m_wr; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        applied++;
        if (addr_out !== e.addr || active !== e.act || wr_out !== e.wr) begin
          bad++;
          $display("FAIL %s: got addr=%h act=%b wr=%b, want addr=%h act=%b wr=%b",
                   e.tag, addr_out, active, wr_out, e.addr, e.act, e.wr);
        end
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 20000);
    bad++;
    $display("FAIL watchdog: got timeout, want completion");
    finish_run();
  end

  initial begin
    #(PERIOD * 2 + 1);
    applied++;
    if (addr_out !== '0 || active !== 1'b0 || wr_out !== 1'b0) begin
      bad++;
      $display("FAIL R10: got addr=%h act=%b wr=%b, want 0 0 0", addr_out, active, wr_out);
    end
    rst_n = 1'b1;

    // R1 + R4 + R5: linear from low bits 01, run past the wrap
    cyc(0, 1, 0, 17'h1A5C1, 0, 0, "R1 load linear");
    for (int k = 0; k < 6; k++) cyc(0, 1, 1, 17'h1A5C1, 0, 0, "R4 R5 linear step");
    // R2: advance with changing address and direction
    cyc(0, 1, 1, 17'h00002, 1, 1, "R2 ignore addr/wr on step");
    cyc(0, 0, 1, 17'h1FFFF, 1, 0, "R2 ignore addr/wr on step");
    // R3: interleaved from 10, write
    cyc(0, 1, 0, 17'h0F3A2, 1, 1, "R1 load interleaved");
    for (int k = 0; k < 5; k++) cyc(0, 1, 1, 17'h0F3A2, 0, 1, "R3 interleaved step");
    // R3 start 11
    cyc(0, 1, 0, 17'h12347, 0, 1, "R1 load interleaved 11");
    for (int k = 0; k < 4; k++) cyc(0, 1, 1, 17'h0, 0, 1, "R3 interleaved step 11");
    // R9: load linear at 11, flip order mid-burst
    cyc(0, 1, 0, 17'h00BB3, 1, 0, "R1 load linear 11");
    for (int k = 0; k < 4; k++) cyc(0, 1, 1, 17'h0, 1, 1, "R9 order change ignored");
    // R6: stall with load-like inputs
    cyc(1, 1, 0, 17'h15555, 0, 1, "R6 stall ignores load");
    cyc(1, 0, 0, 17'h0AAAA, 0, 0, "R6 stall ignores deselect");
    cyc(1, 1, 1, 17'h0, 0, 0, "R6 stall ignores step");
    cyc(0, 1, 1, 17'h0, 0, 0, "R6 resumes after stall");
    // R7: deselect on load stops the burst
    cyc(0, 0, 0, 17'h1CCCC, 0, 1, "R7 deselect stop");
    // R8: steps while idle
    cyc(0, 1, 1, 17'h1CCCC, 0, 1, "R8 idle step");
    cyc(0, 0, 1, 17'h03333, 1, 0, "R8 idle step");
    // new burst after stop, then stall in the middle
    cyc(0, 1, 0, 17'h10000, 0, 0, "R1 reload");
    cyc(0, 1, 1, 17'h0, 0, 0, "R4 step");
    cyc(1, 1, 1, 17'h0, 0, 0, "R6 stall mid-burst");
    cyc(0, 1, 1, 17'h0, 0, 0, "R4 step after stall");
    cyc(0, 0, 1, 17'h0, 0, 0, "R4 idle drive");
    repeat (3) @(posedge clk);
    #2;
    finish_run();
  end
endmodule